// File: doc/BRIEF.md
# Dual Alarm Match Unit

This block watches the running time of a real-time clock and compares it against two independent alarm settings. The weekly alarm holds an hour, a minute and a seven-bit mask with one bit per weekday, so a single setting can cover any set of days, such as weekdays only or the weekend. The daily alarm holds only an hour and a minute, and so matches on every day.

A match is tested only on the one-cycle strobe that marks the start of a new minute (seconds equal to 00), so each matching minute raises its alarm once. A hit sets that alarm's status flag, which the host can poll. The flag stays set until the host writes a 0 to it, which arrives here as a one-cycle clear strobe. Each alarm drives its own active-low interrupt pin, and that pin is low while its flag is set and its enable is 1. All pins are plain control and status signals; no stream data crosses this block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `alarm_pair_top`

## Requirements
- R1: After reset both flags are 0 and both interrupt outputs are 1 (inactive).
- R2: When `minute_tick` is 1, `day_en` is 1, `now_hour` equals `day_hour` and `now_min` equals `day_min`, `day_flag` is 1 after the next rising clock edge.
- R3: The weekly alarm sets `week_flag` on a `minute_tick` with equal hour and minute, `week_en` at 1 and bit `now_dow` of `week_days` set. Weekday codes run 0 to 6 and bit k of the mask enables code k. Code 7 never matches.
- R4: Without `minute_tick`, equal time values set no flag.
- R5: A flag is not set by a match while its enable is 0.
- R6: A set flag holds until its clear strobe (`week_clr` or `day_clr`), and it is 0 after the edge that samples the strobe. If a new match and a clear come in the same cycle, the match wins and the flag stays 1.
- R7: Each interrupt output is 0 exactly while its flag is 1 and its enable is 1, with no clock delay from the enable.
- R8: Dropping an enable to 0 raises that interrupt output at once and leaves the flag's value unchanged.
- R9: The two alarms are independent: a match, clear or enable change on one does not alter the other's flag or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| minute_tick | input | 1 | One-cycle strobe at each minute boundary |
| now_hour | input | 8 | Current hour, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_dow | input | 3 | Current weekday code, 0 to 6 |
| week_en | input | 1 | Weekly alarm enable |
| week_hour | input | 8 | Weekly alarm hour, BCD |
| week_min | input | 8 | Weekly alarm minute, BCD |
| week_days | input | 7 | Weekly alarm weekday mask |
| week_clr | input | 1 | Host clear strobe for the weekly flag |
| day_en | input | 1 | Daily alarm enable |
| day_hour | input | 8 | Daily alarm hour, BCD |
| day_min | input | 8 | Daily alarm minute, BCD |
| day_clr | input | 1 | Host clear strobe for the daily flag |
| week_flag | output | 1 | Weekly alarm status flag |
| day_flag | output | 1 | Daily alarm status flag |
| week_irq_n | output | 1 | Weekly interrupt, active low |
| day_irq_n | output | 1 | Daily interrupt, active low |

## Verification
The assertions assume that every input is synchronous to `clk` and that the clear strobes are single-cycle pulses. They compare hour and minute as raw bytes, so they need no BCD validity. The only input they restrict is the weekday code: a code of 7 is defined as a non-match, and the checker pads the mask to cover it. The bench changes inputs only on falling edges and samples outputs shortly after each rising edge. It raises `minute_tick` for single cycles, which is what a calendar counter delivers.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int BCD_W  = 8;
  localparam int DAYS   = 7;
  localparam int DOW_W  = $clog2(DAYS + 1);

  typedef struct packed {
    logic [BCD_W-1:0] hour;
    logic [BCD_W-1:0] minute;
  } hm_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter bit MASKED = 1'b1
) (
  input  logic             tick,
  input  hm_t              now_hm,
  input  logic [DOW_W-1:0] now_dow,
  input  hm_t              set_hm,
  input  logic [DAYS-1:0]  set_days,
  output logic             hit
);
  localparam int SLOTS = 1 << DOW_W;
  localparam int PAD   = SLOTS - DAYS;

  logic [SLOTS-1:0] day_ok_vec;
  logic             time_eq;

  // Unused weekday slots match only for an unmasked (daily) alarm
  assign day_ok_vec = {{PAD{!MASKED}}, set_days};
  assign time_eq    = (now_hm == set_hm);
  assign hit        = tick && time_eq && day_ok_vec[now_dow];
endmodule

// File: rtl/alarm_latch.sv
module alarm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic clr,
  output logic flag,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)          flag <= 1'b0;
    else if (hit && en)  flag <= 1'b1;   // a fresh event wins over a clear
    else if (clr)        flag <= 1'b0;
  end

  assign irq_n = !(flag && en);
endmodule

// File: rtl/alarm_pair_top.sv
module alarm_pair_top
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             minute_tick,
  input  logic [BCD_W-1:0] now_hour,
  input  logic [BCD_W-1:0] now_min,
  input  logic [DOW_W-1:0] now_dow,
  input  logic             week_en,
  input  logic [BCD_W-1:0] week_hour,
  input  logic [BCD_W-1:0] week_min,
  input  logic [DAYS-1:0]  week_days,
  input  logic             week_clr,
  input  logic             day_en,
  input  logic [BCD_W-1:0] day_hour,
  input  logic [BCD_W-1:0] day_min,
  input  logic             day_clr,
  output logic             week_flag,
  output logic             day_flag,
  output logic             week_irq_n,
  output logic             day_irq_n
);
  localparam int NCH = 2;  // channel 0 weekly, channel 1 daily

  hm_t             now_hm;
  hm_t             set_hm [NCH];
  logic [DAYS-1:0] days   [NCH];
  logic [NCH-1:0]  en_v, clr_v, hit_v, flag_v, irq_v;

  assign now_hm    = '{hour: now_hour, minute: now_min};
  assign set_hm[0] = '{hour: week_hour, minute: week_min};
  assign set_hm[1] = '{hour: day_hour, minute: day_min};
  assign days[0]   = week_days;
  assign days[1]   = '1;
  assign en_v      = {day_en, week_en};
  assign clr_v     = {day_clr, week_clr};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    alarm_match #(.MASKED(c == 0)) u_match (
      .tick     (minute_tick),
      .now_hm   (now_hm),
      .now_dow  (now_dow),
      .set_hm   (set_hm[c]),
      .set_days (days[c]),
      .hit      (hit_v[c])
    );
    alarm_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_v[c]),
      .hit   (hit_v[c]),
      .clr   (clr_v[c]),
      .flag  (flag_v[c]),
      .irq_n (irq_v[c])
    );
  end

  assign week_flag  = flag_v[0];
  assign day_flag   = flag_v[1];
  assign week_irq_n = irq_v[0];
  assign day_irq_n  = irq_v[1];
endmodule

// File: rtl/alarm_pair_checker.sv
module alarm_pair_checker
  import alarm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             minute_tick,
  input logic [BCD_W-1:0] now_hour,
  input logic [BCD_W-1:0] now_min,
  input logic [DOW_W-1:0] now_dow,
  input logic             week_en,
  input logic [BCD_W-1:0] week_hour,
  input logic [BCD_W-1:0] week_min,
  input logic [DAYS-1:0]  week_days,
  input logic             week_clr,
  input logic             day_en,
  input logic [BCD_W-1:0] day_hour,
  input logic [BCD_W-1:0] day_min,
  input logic             day_clr,
  input logic             week_flag,
  input logic             day_flag,
  input logic             week_irq_n,
  input logic             day_irq_n
);
  logic [(1<<DOW_W)-1:0] wide_days;
  assign wide_days = {{((1<<DOW_W)-DAYS){1'b0}}, week_days};

  AST_DAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    minute_tick && day_en && now_hour == day_hour && now_min == day_min |=> day_flag); // R2
  AST_WEEK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    minute_tick && week_en && now_hour == week_hour && now_min == week_min
    && wide_days[now_dow] |=> week_flag); // R3
  AST_WEEK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(week_flag) |-> $past(minute_tick && week_en)); // R4
  AST_DAY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(day_flag) |-> $past(minute_tick && day_en)); // R5
  AST_WEEK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    week_flag && !week_clr |=> week_flag); // R6
  AST_DAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    day_clr && !minute_tick |=> !day_flag); // R6
  AST_WEEK_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    week_flag && week_en |-> !week_irq_n); // R7
  AST_DAY_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !day_en |-> day_irq_n); // R8
endmodule

bind alarm_pair_top alarm_pair_checker i_chk (.*);

// File: tb/test_alarm_pair_top.sv
module test_alarm_pair_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       minute_tick = 1'b0;
  logic [7:0] now_hour = 8'h06, now_min = 8'h59;
  logic [2:0] now_dow = 3'd0;
  logic       week_en = 1'b1, day_en = 1'b1;
  logic [7:0] week_hour = 8'h07, week_min = 8'h30;
  logic [6:0] week_days = 7'b0111110;
  logic [7:0] day_hour = 8'h12, day_min = 8'h00;
  logic       week_clr = 1'b0, day_clr = 1'b0;
  logic       week_flag, day_flag, week_irq_n, day_irq_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] exp;  // {week_flag, day_flag, week_irq_n, day_irq_n}
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  alarm_pair_top i_alarm_pair_top (.*);

  function automatic logic [3:0] outs();
    return {week_flag, day_flag, week_irq_n, day_irq_n};
  endfunction

  // Driver: inputs already set after a falling edge; expectation is for the next rising edge
  task automatic step(input logic tick, input logic [3:0] exp, input string tag);
    item_t it;
    minute_tick = tick;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    minute_tick = 1'b0;
    week_clr = 1'b0;
    day_clr = 1'b0;
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (outs() !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", it.tag, outs(), it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (outs() !== 4'b0011) begin
      n_fail++;
      $display("FAIL R1 in reset: got %b expected %b", outs(), 4'b0011);
    end
    rst_n = 1'b1;
    step(1'b0, 4'b0011, "R1 idle after reset");
    now_hour = 8'h12; now_min = 8'h00;
    step(1'b0, 4'b0011, "R4 equal time without tick");
    step(1'b1, 4'b0110, "R2 daily match sets flag, R9 weekly untouched");
    now_min = 8'h01;
    step(1'b0, 4'b0110, "R6 flag holds");
    day_en = 1'b0;
    step(1'b0, 4'b0111, "R8 enable off raises irq, keeps flag");
    day_en = 1'b1;
    step(1'b0, 4'b0110, "R7 enable back on lowers irq");
    day_clr = 1'b1;
    step(1'b0, 4'b0011, "R6 clear strobe");
    day_en = 1'b0; now_min = 8'h00;
    step(1'b1, 4'b0011, "R5 disabled alarm ignores match");
    day_en = 1'b1;
    now_hour = 8'h07; now_min = 8'h30; now_dow = 3'd0;
    step(1'b1, 4'b0011, "R3 day 0 not in mask");
    now_dow = 3'd3;
    step(1'b1, 4'b1001, "R3 day 3 in mask");
    now_dow = 3'd2; week_clr = 1'b1;
    step(1'b1, 4'b1001, "R6 match beats clear in same cycle");
    week_clr = 1'b1;
    step(1'b0, 4'b0011, "R6 weekly clear");
    now_dow = 3'd7;
    step(1'b1, 4'b0011, "R3 code 7 never matches");
    now_dow = 3'd6;
    step(1'b1, 4'b0011, "R3 day 6 not in weekday mask");
    week_days = 7'b1000001;
    step(1'b1, 4'b1001, "R3 weekend mask matches day 6");
    week_en = 1'b0;
    step(1'b0, 4'b1011, "R8 weekly enable off keeps flag");
    week_en = 1'b1; week_clr = 1'b1;
    step(1'b0, 4'b0011, "R9 weekly clear leaves daily idle");
    day_hour = 8'h07; day_min = 8'h30; now_dow = 3'd0;
    step(1'b1, 4'b1100, "R9 both alarms fire together");
    day_clr = 1'b1;
    step(1'b0, 4'b1001, "R9 daily clear leaves weekly set");
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule